// File: doc/BRIEF.md
# Clock Fan-out Serial Control Slave

This block is the two-wire control port of a clock fan-out device. It answers to the fixed seven-bit address 1101001, so the write header byte is 0xD2 and the read header byte is 0xD3. Behind the port sits a small register file. Its outputs drive thirteen output-enable bits and two drive-strength selects. The bus runs at standard-mode rates. The block samples SCL and SDA with a much faster system clock and pulls SDA low through an open-drain enable (`sda_oe`) to acknowledge bytes and to send read data.

Transfers are block transfers with no register pointer.

- **Write:** the master sends a command byte and a byte-count byte. Both are acknowledged and then thrown away. Data bytes then fill registers 0, 1, 2 and upward.
- **Read:** the slave returns a fixed byte count first. It then returns register contents, always starting from register 0.

Only registers 6 and 7 hold state. Register 6 bit 7 always shows the live level of the mode-select pin. Every other register index takes writes and reads back as zero.

Top module: `clkfan_ctl_slave`

## Requirements
- R1: After reset, all thirteen enables (`en_a` = 0x1F, `en_b` = 0xFF) are 1. Both drive selects are 0, and `sda_oe` is 0.
- R2: Header 0xD2 or 0xD3 is acknowledged. Any other header is not acknowledged. The slave then ignores the bus until the next start condition, so the bytes that follow change no output.
- R3: On a write, the first two bytes after the header are acknowledged and discarded. The k-th data byte (k from 0) goes to register k. Register 6 maps bit 6 to `drv_sdr`, bit 5 to `drv_ddr` and bits 4..0 to `en_a[4:0]`. Register 7 maps bits 7..0 to `en_b[7:0]`.
- R4: Register 6 bit 7 reads as the current level of `mode_pin`. The value written to that bit has no effect.
- R5: On a read, the first byte returned is 0x09. It is followed by registers 0, 1, 2 and upward, each sent MSB first.
- R6: If the master does not acknowledge a read byte, the slave releases SDA and stops sending. A stop condition also leaves SDA released.
- R7: Registers 0 to 5 and 8 acknowledge writes, store nothing and read back as 0x00.
- R8: A start or stop condition inside a byte abandons that byte. Only data bytes already completed have taken effect.
- R9: SCL or SDA pulses shorter than FILT_LEN system clocks (default 4) are ignored. They produce no edge, no start and no stop.
- R10: During a write, the slave pulls SDA low for the ninth clock of every byte after a matching header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| mode_pin | input | 1 | Mode-select pin level, reported in register 6 bit 7 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| en_a | output | 5 | Output enables from register 6 bits 4..0 |
| en_b | output | 8 | Output enables from register 7 |
| drv_sdr | output | 1 | Drive-strength select for the SDR group |
| drv_ddr | output | 1 | Drive-strength select for the DDR group |

## Verification
The hardest situations to reach from the ports are a start or stop arriving partway through a data byte, and pulses that are too short on lines the slave watches for protocol conditions. The bench drives the bus bit by bit, so it can cut a byte after a few bits with a stop or a repeated start. It then reads the register file back to show that only the completed bytes took effect. For the filter, it writes a full block in which every bit carries a two-clock SCL pulse while SCL is low and a two-clock SDA flip while SCL is high. Each flip would be read as a start or stop if it passed the filter.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam logic [6:0] SLV_ADDR  = 7'b1101001;
  localparam logic [7:0] BLK_COUNT = 8'h09;
  localparam int         CTRL_REG  = 6;
  localparam int         OEN_REG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } bus_st_t;

  // header byte addresses this slave (direction bit ignored)
  function automatic logic hdr_hit(input logic [7:0] b);
    return b[7:1] == SLV_ADDR;
  endfunction

  // readback image of the control register: live pin on top
  function automatic logic [7:0] ctrl_image(input logic mode, input logic [6:0] low);
    return {mode, low};
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      cnt   <= '0;
      clean <= 1'b1;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        clean <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import clkctl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             mode_pin,
  output logic [7:0]       rd_data,
  output logic [4:0]       en_a,
  output logic [7:0]       en_b,
  output logic             drv_sdr,
  output logic             drv_ddr
);
  logic [6:0] ctrl_q;
  logic [7:0] oen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 7'b001_1111;
      oen_q  <= 8'hFF;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(CTRL_REG)) ctrl_q <= wr_data[6:0];
      if (wr_idx == IDX_W'(OEN_REG))  oen_q  <= wr_data;
    end
  end

  always_comb begin
    if (rd_idx == IDX_W'(CTRL_REG))     rd_data = ctrl_image(mode_pin, ctrl_q);
    else if (rd_idx == IDX_W'(OEN_REG)) rd_data = oen_q;
    else                                rd_data = 8'h00;
  end

  assign drv_sdr = ctrl_q[6];
  assign drv_ddr = ctrl_q[5];
  assign en_a    = ctrl_q[4:0];
  assign en_b    = oen_q;
endmodule

// File: rtl/clkfan_ctl_slave.sv
module clkfan_ctl_slave
  import clkctl_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int IDX_W    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       mode_pin,
  output logic       sda_oe,
  output logic [4:0] en_a,
  output logic [7:0] en_b,
  output logic       drv_sdr,
  output logic       drv_ddr
);
  // ---- line conditioning (index 0 = SCL, 1 = SDA)
  logic [1:0] raw_v, cln_v;
  assign raw_v = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .raw(raw_v[g]), .clean(cln_v[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = cln_v[0];
  assign sda_f = cln_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // ---- named bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  // ---- protocol state
  bus_st_t          st;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh, tx_sh;
  logic             is_read, addr_phase;
  logic [IDX_W-1:0] byte_no, wr_idx, rd_idx, byte_nx;
  logic [7:0]       rd_data, tx_byte;

  logic byte_done, addr_ok, wr_commit, nack_ev;
  assign byte_done = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign addr_ok   = hdr_hit(rx_sh);
  assign wr_commit = byte_done && !addr_phase && !is_read && (byte_no >= IDX_W'(2));
  assign nack_ev   = (st == ST_MACK) && scl_rise && sda_f;

  assign wr_idx  = byte_no - IDX_W'(2);
  assign rd_idx  = byte_no - IDX_W'(1);
  assign byte_nx = (&byte_no) ? byte_no : byte_no + 1'b1;
  assign tx_byte = (byte_no == '0) ? BLK_COUNT : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      is_read    <= 1'b0;
      addr_phase <= 1'b1;
      byte_no    <= '0;
    end else if (start_ev) begin
      st         <= ST_RX;
      bit_cnt    <= '0;
      is_read    <= 1'b0;
      addr_phase <= 1'b1;
      byte_no    <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            if (addr_phase) begin
              if (addr_ok) begin
                st      <= ST_ACK;
                is_read <= rx_sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st      <= ST_ACK;
              byte_no <= byte_nx;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            addr_phase <= 1'b0;
            bit_cnt    <= '0;
            if (is_read) begin
              tx_sh   <= tx_byte;
              byte_no <= byte_nx;
              st      <= ST_TX;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              st <= ST_MACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (nack_ev) begin
            st <= ST_IDLE;
          end else if (scl_fall) begin
            tx_sh   <= tx_byte;
            byte_no <= byte_nx;
            bit_cnt <= '0;
            st      <= ST_TX;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe = (st == ST_ACK) || ((st == ST_TX) && !tx_sh[7]);

  ctl_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_commit), .wr_idx(wr_idx), .wr_data(rx_sh),
    .rd_idx(rd_idx), .mode_pin(mode_pin), .rd_data(rd_data),
    .en_a(en_a), .en_b(en_b), .drv_sdr(drv_sdr), .drv_ddr(drv_ddr)
  );
endmodule

// File: rtl/ctl_slave_chk.sv
module ctl_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_ev,
  input logic       nack_ev,
  input logic       byte_done,
  input logic       addr_phase,
  input logic       addr_ok,
  input logic       wr_commit,
  input logic       sda_oe,
  input logic [4:0] en_a,
  input logic [7:0] en_b,
  input logic       drv_sdr,
  input logic       drv_ddr
);
  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !sda_oe);

  // R2
  bad_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && addr_phase && !addr_ok) |=> !sda_oe);

  // R10
  byte_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (!addr_phase || addr_ok)) |=> sda_oe);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({en_a, en_b, drv_sdr, drv_ddr}) |-> $past(wr_commit));
endmodule

bind clkfan_ctl_slave ctl_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_ev(stop_ev), .nack_ev(nack_ev),
  .byte_done(byte_done), .addr_phase(addr_phase), .addr_ok(addr_ok),
  .wr_commit(wr_commit), .sda_oe(sda_oe), .en_a(en_a), .en_b(en_b),
  .drv_sdr(drv_sdr), .drv_ddr(drv_ddr)
);

// File: tb/clkfan_ctl_slave_tb.sv
module clkfan_ctl_slave_tb;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1, mode_pin = 1'b1;
  logic sda_line, sda_oe, drv_sdr, drv_ddr;
  logic [4:0] en_a;
  logic [7:0] en_b;
  int n_cmp = 0, n_bad = 0;

  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  clkfan_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .mode_pin(mode_pin), .sda_oe(sda_oe), .en_a(en_a), .en_b(en_b),
    .drv_sdr(drv_sdr), .drv_ddr(drv_ddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ex(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  // scoreboard monitor
  initial begin
    logic [7:0] g, e;
    string t;
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          e = 8'hxx; t = "R5 unexpected byte";
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
        end
        chk(t, {24'd0, g}, {24'd0, e});
      end
    end
  end

  task automatic wq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    sda_drv = b;
    if (glitch) begin
      repeat (5) @(posedge clk);
      scl_drv = 1'b1; repeat (2) @(posedge clk); scl_drv = 1'b0;
    end
    wq(); scl_drv = 1'b1; wq();
    if (glitch) begin
      sda_drv = ~b; repeat (2) @(posedge clk); sda_drv = b;
    end
    wq(); scl_drv = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch);
    sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
    @(negedge clk); ack = ~sda_line;
    wq(); scl_drv = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic do_ack);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_drv = 1'b1; wq();
      @(negedge clk); b[i] = sda_line;
      wq(); scl_drv = 1'b0;
    end
    wq(); sda_drv = ~do_ack; scl_drv = 1'b1; wq(); wq();
    scl_drv = 1'b0; wq(); sda_drv = 1'b1;
  endtask

  task automatic rd_block(input int n);
    logic [7:0] b;
    logic a;
    bus_start();
    send_byte(8'hD3, 1'b0, a);
    chk("R2 read header acked", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      got_q.push_back(b);
    end
    @(negedge clk);
    chk("R6 SDA released after master NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic wr_head(input logic glitch);
    logic a;
    bus_start();
    send_byte(8'hD2, glitch, a); chk("R2 write header acked", a, 1);
    send_byte(8'h5A, glitch, a); chk("R3 command byte acked", a, 1);
    send_byte(8'h33, glitch, a); chk("R3 count byte acked", a, 1);
  endtask

  task automatic check_cfg(input string tag, input logic [4:0] a, input logic [7:0] b,
                           input logic s, input logic d);
    @(negedge clk);
    chk({tag, " en_a"}, en_a, a);
    chk({tag, " en_b"}, en_b, b);
    chk({tag, " drv_sdr"}, drv_sdr, s);
    chk({tag, " drv_ddr"}, drv_ddr, d);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    check_cfg("R1 reset", 5'h1F, 8'hFF, 1'b0, 1'b0);
    chk("R1 sda_oe idle", sda_oe, 0);

    // R5 / R7 readback of defaults, mode pin high
    ex(8'h09, "R5 byte count first");
    for (int i = 0; i < 6; i++) ex(8'h00, "R7 unimplemented reads zero");
    ex(8'h9F, "R4 reg6 default with pin high");
    ex(8'hFF, "R5 reg7 default");
    ex(8'h00, "R7 reg8 reads zero");
    rd_block(10);

    // R3 / R10 block write of all nine registers
    wr_head(1'b0);
    for (int i = 0; i < 9; i++) begin
      send_byte(i == 6 ? 8'hE5 : (i == 7 ? 8'h3C : 8'hA0 + 8'(i)), 1'b0, a);
      chk("R10 data byte acked", a, 1);
    end
    bus_stop();
    check_cfg("R3 after write", 5'h05, 8'h3C, 1'b1, 1'b1);

    // R4 read-only bit follows pin, written value ignored
    mode_pin = 1'b0;
    ex(8'h09, "R5 byte count first");
    for (int i = 0; i < 6; i++) ex(8'h00, "R7 written but reads zero");
    ex(8'h65, "R4 reg6 bit7 follows pin low");
    ex(8'h3C, "R5 reg7 readback");
    ex(8'h00, "R7 reg8 reads zero");
    rd_block(10);
    mode_pin = 1'b1;
    ex(8'h09, "R5 byte count first");
    for (int i = 0; i < 6; i++) ex(8'h00, "R7 reads zero");
    ex(8'hE5, "R4 reg6 bit7 follows pin high");
    rd_block(8);

    // R2 wrong header: no ack, following bytes ignored
    bus_start();
    send_byte(8'hA4, 1'b0, a);
    chk("R2 wrong header not acked", a, 0);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'h00, 1'b0, a);
      chk("R2 ignored byte not acked", a, 0);
    end
    bus_stop();
    check_cfg("R2 after wrong header", 5'h05, 8'h3C, 1'b1, 1'b1);

    // R8 stop inside reg6 byte
    wr_head(1'b0);
    for (int i = 0; i < 6; i++) send_byte(8'h00, 1'b0, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    bus_stop();
    check_cfg("R8 stop mid-byte", 5'h05, 8'h3C, 1'b1, 1'b1);

    // R8 reg6 complete, repeated start inside reg7 byte
    wr_head(1'b0);
    for (int i = 0; i < 7; i++) send_byte(8'h00, 1'b0, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    bus_start();
    bus_stop();
    check_cfg("R8 start mid-byte", 5'h00, 8'h3C, 1'b0, 1'b0);

    // R9 every bit carries short SCL and SDA pulses
    wr_head(1'b1);
    for (int i = 0; i < 8; i++) begin
      send_byte(i == 7 ? 8'hC3 : 8'h00, 1'b1, a);
      chk("R9 glitched byte acked", a, 1);
    end
    bus_stop();
    check_cfg("R9 glitched write", 5'h00, 8'hC3, 1'b0, 1'b0);

    ex(8'h09, "R5 byte count first");
    for (int i = 0; i < 6; i++) ex(8'h00, "R7 reads zero");
    ex(8'h80, "R4 reg6 image after glitched write");
    ex(8'hC3, "R9 reg7 after glitched write");
    rd_block(9);

    repeat (10) @(posedge clk);
    chk("R5 all expected bytes received", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule